// File: doc/BRIEF.md
# Performance-Level Clock Configuration Selector

This block controls one root clock generator whose divider settings are picked by hardware from a table of eight performance levels. Software fills the table through a small register port. For each level the table holds a source select, a pre-divider, a fractional-divider mode, an M value and an N value. A peripheral then asks for a level on a dedicated request input. While switching is enabled, the block copies that level's settings into the active divider configuration with no software action.

The active configuration is driven on output ports: source select, effective pre-divide, mode, M and effective N. It stands in for the real clock mux and dividers. N is stored in an encoded form, the bitwise inverse of (N − M). The block decodes it back to a plain N before driving the outputs. A command register carries the switching enable and reports the level that is currently active.

Top module: `perf_clk_sel`

## Requirements
- R1: There are 8 levels, indexed 0 to 7. A valid request of 0..7 made while switching is enabled takes effect at the clock edge that samples the request. From that edge on, the outputs show that level's settings and the command register shows it as the active level.
- R2: The command register sits at byte offset 0x14. Bit 0 is the read/write switching enable. Bits 4:1 read back the active level, and writes to them are ignored. All other bits read as 0.
- R3: The table sits at three byte offsets, each with a stride of 4 per level L. The configuration word is at 0x1C+4L, with the pre-divide field in bits 4:0, the source select in bits 10:8 and the mode in bits 13:12. The M word is at 0x5C+4L, in bits 7:0. The N word is at 0x9C+4L, in bits 7:0. Unimplemented bits read as 0.
- R4: A pre-divide field of 0 drives an effective pre-divide of 1. Any other value drives that value.
- R5: For a nonzero mode, the outputs give M = stored M and N = (~stored N & 0xFF) + M, on 9 bits. For mode 0 the M/N divider is bypassed and both M and N outputs are 0.
- R6: While switching is disabled, requests only update the pending level, and the outputs and the active level hold. When switching is then enabled with a pending level that differs from the active one, that level is loaded one clock after the enabling write.
- R7: A request above 7 is ignored, and the pending and active levels are kept.
- R8: All active outputs change together and only on a level change. Rewriting the table entry of the active level, or requesting the level that is already active, leaves the outputs unchanged.
- R9: The write and read ports are always ready. A read answers one cycle later with rd_resp_valid. Unmapped or misaligned offsets read as 0.
- R10: After reset, switching is disabled, the active and pending levels are 0, the table is zero, and the outputs are source 0, pre-divide 1, mode 0, M 0 and N 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Register write request |
| wr_ready | output | 1 | Write accepted (always 1) |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_valid | input | 1 | Register read request |
| rd_ready | output | 1 | Read accepted (always 1) |
| rd_addr | input | 8 | Read byte offset |
| rd_resp_valid | output | 1 | Read data valid, one cycle after the request |
| rd_data | output | 32 | Read data |
| lvl_req_valid | input | 1 | Level request strobe from the peripheral |
| lvl_req | input | 4 | Requested performance level |
| clk_src_sel | output | 3 | Active source select |
| clk_pre_div | output | 5 | Active effective pre-divide |
| clk_mnd_mode | output | 2 | Active fractional-divider mode |
| clk_m | output | 8 | Active M |
| clk_n | output | 9 | Active effective N |

## Verification
The properties assume that rst_n is held low across at least one clock edge before activity, and that every input changes only between clock edges. They also assume that lvl_req is meaningful only while lvl_req_valid is high. The bench drives every strobe for exactly one cycle, changes inputs on the falling edge, and never sends a level request in the same cycle as a register write. Under these conditions the ordering between a table rewrite and a level load is never ambiguous.

// File: rtl/perf_clk_pkg.sv
package perf_clk_pkg;
  localparam int NUM_LVL   = 8;
  localparam int LVL_W     = $clog2(NUM_LVL);
  localparam int LVL_FLD_W = 4;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 32;
  localparam int PDIV_W    = 5;
  localparam int SRC_W     = 3;
  localparam int MODE_W    = 2;
  localparam int MND_W     = 8;
  localparam int SRC_LSB   = 8;
  localparam int MODE_LSB  = 12;
  localparam int STRIDE    = 4;

  localparam logic [ADDR_W-1:0] OFS_CMD = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CFG = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_M   = 8'h5C;
  localparam logic [ADDR_W-1:0] OFS_N   = 8'h9C;
  localparam logic [ADDR_W-1:0] SPAN    = ADDR_W'(NUM_LVL * STRIDE);

  typedef enum logic [2:0] {RG_NONE, RG_CMD, RG_CFG, RG_M, RG_N} reg_kind_e;

  typedef struct packed {
    reg_kind_e        kind;
    logic [LVL_W-1:0] idx;
  } reg_sel_t;

  typedef struct packed {
    logic [PDIV_W-1:0] pdiv;
    logic [SRC_W-1:0]  src;
    logic [MODE_W-1:0] mode;
  } lvl_cfg_t;

  typedef struct packed {
    logic [SRC_W-1:0]  src;
    logic [PDIV_W-1:0] pdiv;
    logic [MODE_W-1:0] mode;
    logic [MND_W-1:0]  m;
    logic [MND_W:0]    n;
  } act_cfg_t;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return (off < SPAN) && (off[1:0] == 2'b00);
  endfunction

  function automatic logic [LVL_W-1:0] window_idx(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = a - base;
    return off[LVL_W+1:2];
  endfunction

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s.kind = RG_NONE;
    s.idx  = '0;
    if (a == OFS_CMD) begin
      s.kind = RG_CMD;
    end else if (in_window(a, OFS_CFG)) begin
      s.kind = RG_CFG;
      s.idx  = window_idx(a, OFS_CFG);
    end else if (in_window(a, OFS_M)) begin
      s.kind = RG_M;
      s.idx  = window_idx(a, OFS_M);
    end else if (in_window(a, OFS_N)) begin
      s.kind = RG_N;
      s.idx  = window_idx(a, OFS_N);
    end
    return s;
  endfunction

  function automatic lvl_cfg_t unpack_cfg(input logic [DATA_W-1:0] w);
    lvl_cfg_t c;
    c.pdiv = w[PDIV_W-1:0];
    c.src  = w[SRC_LSB +: SRC_W];
    c.mode = w[MODE_LSB +: MODE_W];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] pack_cfg(input lvl_cfg_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[PDIV_W-1:0]         = c.pdiv;
    w[SRC_LSB +: SRC_W]   = c.src;
    w[MODE_LSB +: MODE_W] = c.mode;
    return w;
  endfunction

  function automatic act_cfg_t resolve_level(input lvl_cfg_t c,
                                             input logic [MND_W-1:0] m,
                                             input logic [MND_W-1:0] n_enc);
    act_cfg_t r;
    r.src  = c.src;
    r.pdiv = (c.pdiv == '0) ? PDIV_W'(1) : c.pdiv;
    r.mode = c.mode;
    if (c.mode != '0) begin
      r.m = m;
      r.n = {1'b0, ~n_enc} + {1'b0, m};
    end else begin
      r.m = '0;
      r.n = '0;
    end
    return r;
  endfunction

  function automatic act_cfg_t reset_cfg();
    act_cfg_t r;
    r      = '0;
    r.pdiv = PDIV_W'(1);
    return r;
  endfunction
endpackage

// File: rtl/perf_lvl_bank.sv
module perf_lvl_bank
  import perf_clk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  reg_sel_t             wr_sel,
  input  logic [DATA_W-1:0]    wr_word,
  input  reg_sel_t             rd_sel,
  output logic [DATA_W-1:0]    rd_word,
  input  logic [LVL_W-1:0]     load_lvl,
  output act_cfg_t             load_cfg
);
  lvl_cfg_t         cfg_q [NUM_LVL];
  logic [MND_W-1:0] m_q   [NUM_LVL];
  logic [MND_W-1:0] n_q   [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    logic hit;
    assign hit = wr_en && (wr_sel.idx == LVL_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[g] <= '0;
        m_q[g]   <= '0;
        n_q[g]   <= '0;
      end else if (hit) begin
        if (wr_sel.kind == RG_CFG) cfg_q[g] <= unpack_cfg(wr_word);
        if (wr_sel.kind == RG_M)   m_q[g]   <= wr_word[MND_W-1:0];
        if (wr_sel.kind == RG_N)   n_q[g]   <= wr_word[MND_W-1:0];
      end
    end
  end

  always_comb begin
    case (rd_sel.kind)
      RG_CFG:  rd_word = pack_cfg(cfg_q[rd_sel.idx]);
      RG_M:    rd_word = DATA_W'(m_q[rd_sel.idx]);
      RG_N:    rd_word = DATA_W'(n_q[rd_sel.idx]);
      default: rd_word = '0;
    endcase
  end

  assign load_cfg = resolve_level(cfg_q[load_lvl], m_q[load_lvl], n_q[load_lvl]);
endmodule

// File: rtl/perf_lvl_tracker.sv
module perf_lvl_tracker
  import perf_clk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_en,
  input  logic                 req_valid,
  input  logic [LVL_FLD_W-1:0] req,
  output logic [LVL_W-1:0]     pend_lvl,
  output logic [LVL_W-1:0]     act_lvl,
  output logic [LVL_W-1:0]     load_lvl,
  output logic                 load_evt
);
  logic req_ok;

  assign req_ok   = req_valid && (req < LVL_FLD_W'(NUM_LVL));
  assign load_lvl = req_ok ? req[LVL_W-1:0] : pend_lvl;
  assign load_evt = sw_en && (load_lvl != act_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_lvl <= '0;
      act_lvl  <= '0;
    end else begin
      pend_lvl <= load_lvl;
      if (load_evt) act_lvl <= load_lvl;
    end
  end
endmodule

// File: rtl/perf_act_cfg.sv
module perf_act_cfg
  import perf_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load_evt,
  input  act_cfg_t load_cfg,
  output act_cfg_t act
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        act <= reset_cfg();
    else if (load_evt) act <= load_cfg;
  end
endmodule

// File: rtl/perf_clk_sel.sv
module perf_clk_sel
  import perf_clk_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_resp_valid,
  output logic [DATA_W-1:0]    rd_data,
  input  logic                 lvl_req_valid,
  input  logic [LVL_FLD_W-1:0] lvl_req,
  output logic [SRC_W-1:0]     clk_src_sel,
  output logic [PDIV_W-1:0]    clk_pre_div,
  output logic [MODE_W-1:0]    clk_mnd_mode,
  output logic [MND_W-1:0]     clk_m,
  output logic [MND_W:0]       clk_n
);
  reg_sel_t          wr_sel, rd_sel;
  logic              sw_en;
  logic              wr_fire, rd_fire;
  logic [DATA_W-1:0] bank_word;
  logic [DATA_W-1:0] rd_word;
  logic [LVL_W-1:0]  pend_lvl, act_lvl, load_lvl;
  logic              load_evt;
  act_cfg_t          load_cfg, act;
  logic              unused_wr_bits;

  assign wr_ready = 1'b1;
  assign rd_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;
  assign rd_fire  = rd_valid && rd_ready;
  assign wr_sel   = decode_addr(wr_addr);
  assign rd_sel   = decode_addr(rd_addr);
  assign unused_wr_bits = ^wr_data[DATA_W-1:MODE_LSB+MODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             sw_en <= 1'b0;
    else if (wr_fire && wr_sel.kind == RG_CMD) sw_en <= wr_data[0];
  end

  perf_lvl_bank u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_fire),
    .wr_sel   (wr_sel),
    .wr_word  (wr_data),
    .rd_sel   (rd_sel),
    .rd_word  (bank_word),
    .load_lvl (load_lvl),
    .load_cfg (load_cfg)
  );

  perf_lvl_tracker u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_en     (sw_en),
    .req_valid (lvl_req_valid),
    .req       (lvl_req),
    .pend_lvl  (pend_lvl),
    .act_lvl   (act_lvl),
    .load_lvl  (load_lvl),
    .load_evt  (load_evt)
  );

  perf_act_cfg u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .load_cfg (load_cfg),
    .act      (act)
  );

  always_comb begin
    if (rd_sel.kind == RG_CMD)
      rd_word = DATA_W'({LVL_FLD_W'(act_lvl), sw_en});
    else
      rd_word = bank_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_resp_valid <= 1'b0;
      rd_data       <= '0;
    end else begin
      rd_resp_valid <= rd_fire;
      if (rd_fire) rd_data <= rd_word;
    end
  end

  assign clk_src_sel  = act.src;
  assign clk_pre_div  = act.pdiv;
  assign clk_mnd_mode = act.mode;
  assign clk_m        = act.m;
  assign clk_n        = act.n;
endmodule

// File: rtl/perf_clk_sel_chk.sv
module perf_clk_sel_chk
  import perf_clk_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rd_valid,
  input logic                 rd_resp_valid,
  input logic                 lvl_req_valid,
  input logic [LVL_FLD_W-1:0] lvl_req,
  input logic                 sw_en,
  input logic [LVL_W-1:0]     pend_lvl,
  input logic [LVL_W-1:0]     act_lvl,
  input logic [LVL_W-1:0]     load_lvl,
  input logic                 load_evt,
  input logic [SRC_W-1:0]     clk_src_sel,
  input logic [PDIV_W-1:0]    clk_pre_div,
  input logic [MODE_W-1:0]    clk_mnd_mode,
  input logic [MND_W-1:0]     clk_m,
  input logic [MND_W:0]       clk_n
);
  p_load_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> act_lvl == $past(load_lvl));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> $stable(act_lvl));

  p_high_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_req_valid && lvl_req >= LVL_FLD_W'(NUM_LVL)) |=> $stable(pend_lvl));

  p_atomic_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> ($stable(clk_src_sel) && $stable(clk_pre_div) &&
                   $stable(clk_mnd_mode) && $stable(clk_m) && $stable(clk_n)));

  p_pdiv_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clk_pre_div != '0);

  p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_mnd_mode == '0 |-> (clk_m == '0 && clk_n == '0));

  p_n_covers_m_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clk_n >= {1'b0, clk_m});

  p_rd_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> rd_resp_valid);

  p_rd_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> !rd_resp_valid);
endmodule

bind perf_clk_sel perf_clk_sel_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rd_valid      (rd_valid),
  .rd_resp_valid (rd_resp_valid),
  .lvl_req_valid (lvl_req_valid),
  .lvl_req       (lvl_req),
  .sw_en         (sw_en),
  .pend_lvl      (pend_lvl),
  .act_lvl       (act_lvl),
  .load_lvl      (load_lvl),
  .load_evt      (load_evt),
  .clk_src_sel   (clk_src_sel),
  .clk_pre_div   (clk_pre_div),
  .clk_mnd_mode  (clk_mnd_mode),
  .clk_m         (clk_m),
  .clk_n         (clk_n)
);

// File: tb/perf_clk_sel_test.sv
`timescale 1ns/1ps
module perf_clk_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_valid = 1'b0, lvl_req_valid = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  lvl_req = '0;
  logic        wr_ready, rd_ready, rd_resp_valid;
  logic [31:0] rd_data;
  logic [2:0]  clk_src_sel;
  logic [4:0]  clk_pre_div;
  logic [1:0]  clk_mnd_mode;
  logic [7:0]  clk_m;
  logic [8:0]  clk_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  perf_clk_sel uut (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .rd_resp_valid(rd_resp_valid), .rd_data(rd_data),
    .lvl_req_valid(lvl_req_valid), .lvl_req(lvl_req),
    .clk_src_sel(clk_src_sel), .clk_pre_div(clk_pre_div), .clk_mnd_mode(clk_mnd_mode),
    .clk_m(clk_m), .clk_n(clk_n)
  );

  function automatic int exp_pdiv(input int f);
    return (f == 0) ? 1 : f;
  endfunction

  function automatic int exp_n(input int m, input int nreg);
    return m + (255 - nreg);
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int src, input int pdiv,
                         input int mode, input int m, input int n);
    chk(req, "src", clk_src_sel, src);
    chk(req, "pdiv", clk_pre_div, pdiv);
    chk(req, "mode", clk_mnd_mode, mode);
    chk(req, "m", clk_m, m);
    chk(req, "n", clk_n, n);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
    rd_valid = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_valid = 1'b0;
    d = rd_data;
    checks++;
    if (!rd_resp_valid) begin
      errors++;
      $display("FAIL R9 rd_resp_valid actual=0 expected=1");
    end
  endtask

  task automatic request(input logic [3:0] l);
    lvl_req_valid = 1'b1; lvl_req = l;
    @(posedge clk); @(negedge clk);
    lvl_req_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_out("R10", 0, 1, 0, 0, 0);
    reg_rd(8'h14, d); chk("R10", "cmd", d, 0);
    reg_rd(8'h28, d); chk("R10", "cfg3", d, 0);
    chk("R9", "ready", {wr_ready, rd_ready}, 2'b11);
  endtask

  task automatic t_program();
    logic [31:0] d;
    reg_wr(8'h28, 32'h0000_2205); reg_wr(8'h68, 32'h3); reg_wr(8'hA8, 32'hF8);
    reg_wr(8'h30, 32'h0000_0400); reg_wr(8'h70, 32'h12); reg_wr(8'hB0, 32'h34);
    reg_wr(8'h38, 32'hFFFF_FFFF); reg_wr(8'h78, 32'hFFFF_FFFF); reg_wr(8'hB8, 32'hFFFF_FFFF);
    reg_rd(8'h28, d); chk("R3", "cfg3", d, 32'h2205);
    reg_rd(8'h38, d); chk("R3", "cfg7 mask", d, 32'h371F);
    reg_rd(8'h78, d); chk("R3", "m7", d, 32'hFF);
    reg_rd(8'hB8, d); chk("R3", "n7", d, 32'hFF);
    reg_rd(8'h70, d); chk("R3", "m5", d, 32'h12);
  endtask

  task automatic t_disabled_then_enable();
    logic [31:0] d;
    request(4'd3);
    chk_out("R6", 0, 1, 0, 0, 0);
    reg_rd(8'h14, d); chk("R6", "cmd", d, 0);
    reg_wr(8'h14, 32'h1);
    chk_out("R6", 0, 1, 0, 0, 0);
    @(posedge clk); @(negedge clk);
    chk_out("R6", 2, exp_pdiv(5), 2, 3, exp_n(3, 8'hF8));
    reg_rd(8'h14, d); chk("R1", "cmd lvl3", d, 32'h7);
  endtask

  task automatic t_switch();
    request(4'd5);
    chk_out("R4", 4, exp_pdiv(0), 0, 0, 0);
    request(4'd7);
    chk_out("R5", 7, exp_pdiv(31), 3, 255, exp_n(255, 255));
  endtask

  task automatic t_high_req();
    logic [31:0] d;
    request(4'd5);
    request(4'd9);
    chk_out("R7", 4, 1, 0, 0, 0);
    request(4'd15);
    @(posedge clk); @(negedge clk);
    chk_out("R7", 4, 1, 0, 0, 0);
    reg_rd(8'h14, d); chk("R7", "cmd lvl5", d, 32'hB);
    reg_wr(8'h14, 32'hFFFF_FFFF);
    reg_rd(8'h14, d); chk("R2", "cmd ro bits", d, 32'hB);
  endtask

  task automatic t_rewrite_active();
    reg_wr(8'h30, 32'h0000_0107);
    chk_out("R8", 4, 1, 0, 0, 0);
    request(4'd5);
    chk_out("R8", 4, 1, 0, 0, 0);
    request(4'd7);
    chk_out("R8", 7, 31, 3, 255, 255);
    request(4'd5);
    chk_out("R8", 1, 7, 0, 0, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    reg_rd(8'h00, d); chk("R9", "rd 00", d, 0);
    reg_rd(8'h18, d); chk("R9", "rd 18", d, 0);
    reg_rd(8'h1D, d); chk("R9", "rd 1D", d, 0);
    reg_rd(8'hC0, d); chk("R9", "rd C0", d, 0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    reg_wr(8'h14, 32'h0);
    request(4'd3);
    @(posedge clk); @(negedge clk);
    chk_out("R6", 1, 7, 0, 0, 0);
    reg_rd(8'h14, d); chk("R6", "cmd off", d, 32'hA);
    reg_wr(8'h14, 32'h1);
    @(posedge clk); @(negedge clk);
    chk_out("R6", 2, 5, 2, 3, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_disabled_then_enable();
    t_switch();
    t_high_req();
    t_rewrite_active();
    t_unmapped();
    t_pending();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule